// File: doc/BRIEF.md
# Video Capture Port Front End

This block sits at the input of a video capture port. It takes a 16-bit pixel stream with four control inputs: a pixel qualifier, a line sync, a field indicator and a frame sync. Software sets the active level of each control input. After it applies those levels, the block finds the leading edges of line and frame sync. It keeps a pixel count for the current line and a line count for the current frame. In interlaced mode it records which field is arriving.

Accepted pixels are packed into two banks of 32 words, which is one 64-byte burst per bank. While one bank fills, a downstream reader empties the other over a valid/ready handshake, one word per transfer. A bank is handed to the reader when it fills or when a line or frame boundary closes it early. Every word leaves with three tags: last-of-bank, end-of-line and field.

The block also pulses line and frame boundary strobes. It raises a sticky overflow flag when it has to drop a pixel.

Top module: `vcap_frontend`

## Requirements
- R1: Bit i of `cfg_pol` set to 1 makes the matching video input active-low; bit 0 is the pixel qualifier, bit 1 the line sync, bit 2 the field indicator and bit 3 the frame sync. An input held at its inactive level has no effect.
- R2: `pix_count` counts qualified pixels since the last leading edge of line sync. On that edge it restarts at 0, or at 1 if a pixel is qualified in the same cycle. Counts are visible two clock edges after the input cycle.
- R3: `line_count` counts line-sync leading edges since the last frame-sync leading edge, and goes to 0 on a frame-sync leading edge.
- R4: In interlaced mode (`cfg_interlace`=1), `field_id` takes the field indicator's active state on each frame-sync leading edge. In progressive mode that edge loads 0. `field_id` changes at no other time.
- R5: `line_start` and `frame_start` pulse high for exactly one cycle, two clock edges after the cycle in which the matching sync input reaches its active level.
- R6: 32 pixels in a bank make it readable. Its words leave in arrival order, with `out_last` high only on the 32nd and `out_eol` low.
- R7: A line-sync or frame-sync leading edge closes a partly filled bank. The closed bank becomes readable with only the words it holds, and `out_eol` and `out_last` are both high on its final word. A leading edge that arrives while the filling bank is empty has no effect.
- R8: Filling continues into the second bank while the first waits for the reader, so 64 pixels are held with no reader activity and come out in order.
- R9: A pixel that arrives while both banks wait for the reader is dropped and sets `overflow`, which stays high until reset. Words already stored are unaffected.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and the word tags hold steady.
- R11: `out_field` carries the field in force when the word was written (0 in progressive mode).
- R12: After reset `out_valid`, `overflow`, `field_id`, `line_start`, `frame_start`, `pix_count` and `line_count` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_pol | input | 4 | Active-low select per input: {frame, field, line, qualifier} |
| cfg_interlace | input | 1 | 1 = interlaced field tracking, 0 = progressive |
| vid_valid | input | 1 | Pixel qualifier |
| vid_line | input | 1 | Line sync |
| vid_field | input | 1 | Field indicator |
| vid_frame | input | 1 | Frame sync |
| vid_data | input | 16 | Pixel value |
| out_ready | input | 1 | Reader accepts the presented word |
| out_valid | output | 1 | A word is presented |
| out_data | output | 16 | Presented pixel |
| out_last | output | 1 | Final word of the current bank |
| out_eol | output | 1 | Final word of a bank closed by a sync edge |
| out_field | output | 1 | Field tag of the presented word |
| pix_count | output | 12 | Pixels since line start |
| line_count | output | 11 | Lines since frame start |
| field_id | output | 1 | Current field |
| line_start | output | 1 | One-cycle line boundary strobe |
| frame_start | output | 1 | One-cycle frame boundary strobe |
| overflow | output | 1 | Sticky dropped-pixel flag |

## Verification
A bank-state error shows at the handshake within one burst. A wrong fill pointer or length reorders or truncates words. It can also move `out_last` off the 32nd word or off the closing word. A lost ready bit either stalls `out_valid` or lets the reader repeat a bank. A wrong busy decision shows as an early or missing `overflow` on the 65th undrained pixel. Edge-detector and polarity faults show in `pix_count`, `line_count` and the strobes two edges after the stimulating cycle, so the directed tests sample there.

// File: rtl/vcap_pkg.sv
package vcap_pkg;

  // Normalized control bits, index order matches cfg_pol.
  localparam int unsigned CtlQual  = 0;
  localparam int unsigned CtlLine  = 1;
  localparam int unsigned CtlField = 2;
  localparam int unsigned CtlFrame = 3;

  // Convert raw input levels to "asserted" levels.
  function automatic logic [3:0] apply_polarity(input logic [3:0] raw,
                                                input logic [3:0] low_act);
    return raw ^ low_act;
  endfunction

  // Rising edge of an asserted level.
  function automatic logic lead_edge(input logic now_lvl, input logic prev_lvl);
    return now_lvl & ~prev_lvl;
  endfunction

endpackage

// File: rtl/vcap_sync.sv
module vcap_sync
  import vcap_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    cfg_pol,
  input  logic          vid_valid,
  input  logic          vid_line,
  input  logic          vid_field,
  input  logic          vid_frame,
  input  logic [DW-1:0] vid_data,
  output logic          s_valid,
  output logic          s_field,
  output logic [DW-1:0] s_data,
  output logic          line_edge,
  output logic          frame_edge
);

  logic [3:0]    lvl_q;
  logic          line_prev_q;
  logic          frame_prev_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q        <= '0;
      line_prev_q  <= 1'b0;
      frame_prev_q <= 1'b0;
      data_q       <= '0;
    end else begin
      lvl_q        <= apply_polarity({vid_frame, vid_field, vid_line, vid_valid}, cfg_pol);
      line_prev_q  <= lvl_q[CtlLine];
      frame_prev_q <= lvl_q[CtlFrame];
      data_q       <= vid_data;
    end
  end

  assign s_valid    = lvl_q[CtlQual];
  assign s_field    = lvl_q[CtlField];
  assign s_data     = data_q;
  assign line_edge  = lead_edge(lvl_q[CtlLine], line_prev_q);
  assign frame_edge = lead_edge(lvl_q[CtlFrame], frame_prev_q);

endmodule

// File: rtl/vcap_timing.sv
module vcap_timing #(
  parameter int unsigned PW = 12,
  parameter int unsigned LW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_interlace,
  input  logic          s_valid,
  input  logic          s_field,
  input  logic          line_edge,
  input  logic          frame_edge,
  output logic [PW-1:0] pix_count,
  output logic [LW-1:0] line_count,
  output logic          field_id,
  output logic          field_nxt,
  output logic          line_start,
  output logic          frame_start
);

  function automatic logic [PW-1:0] next_pix(input logic [PW-1:0] cur,
                                             input logic restart,
                                             input logic qual);
    logic [PW-1:0] inc;
    inc = {{(PW-1){1'b0}}, qual};
    return restart ? inc : cur + inc;
  endfunction

  function automatic logic [LW-1:0] next_line(input logic [LW-1:0] cur,
                                              input logic fr_edge,
                                              input logic ln_edge);
    if (fr_edge) return '0;
    if (ln_edge) return cur + LW'(1);
    return cur;
  endfunction

  logic [PW-1:0] pix_q;
  logic [LW-1:0] line_q;
  logic          field_q;
  logic          ls_q;
  logic          fs_q;

  assign field_nxt = frame_edge ? (cfg_interlace & s_field) : field_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q   <= '0;
      line_q  <= '0;
      field_q <= 1'b0;
      ls_q    <= 1'b0;
      fs_q    <= 1'b0;
    end else begin
      pix_q   <= next_pix(pix_q, line_edge, s_valid);
      line_q  <= next_line(line_q, frame_edge, line_edge);
      field_q <= field_nxt;
      ls_q    <= line_edge;
      fs_q    <= frame_edge;
    end
  end

  assign pix_count   = pix_q;
  assign line_count  = line_q;
  assign field_id    = field_q;
  assign line_start  = ls_q;
  assign frame_start = fs_q;

endmodule

// File: rtl/vcap_dbuf.sv
module vcap_dbuf #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_field,
  input  logic          close_req,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_last,
  output logic          out_eol,
  output logic          out_field,
  output logic          overflow,
  output logic          pix_drop,
  output logic [1:0]    bank_ready
);

  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = AW + 1;

  logic          wsel_q, rsel_q;
  logic [CW-1:0] wcnt_q, rcnt_q;
  logic          ovf_q;

  logic          close_now, tgt_sel, tgt_busy, do_write, fill_done;
  logic [CW-1:0] tgt_cnt;
  logic          rd_fire, rd_last;

  logic [1:0][CW-1:0] blen;
  logic [1:0]         beol;
  logic [1:0]         bfld;
  logic [1:0][DW-1:0] rd_word;

  // Write-side decision: an early close moves filling to the other bank
  // before this cycle's pixel is placed.
  always_comb begin
    close_now = close_req && (wcnt_q != '0);
    tgt_sel   = close_now ? ~wsel_q : wsel_q;
    tgt_cnt   = close_now ? '0 : wcnt_q;
    tgt_busy  = bank_ready[tgt_sel];
    do_write  = wr_en && !tgt_busy;
    pix_drop  = wr_en && tgt_busy;
    fill_done = do_write && (tgt_cnt == CW'(DEPTH - 1));
  end

  assign out_valid = bank_ready[rsel_q];
  assign rd_fire   = out_valid && out_ready;
  assign rd_last   = (rcnt_q == blen[rsel_q] - CW'(1));
  assign out_data  = rd_word[rsel_q];
  assign out_last  = out_valid && rd_last;
  assign out_eol   = out_valid && rd_last && beol[rsel_q];
  assign out_field = bfld[rsel_q];
  assign overflow  = ovf_q;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic          rdy_q;
    logic [CW-1:0] len_q;
    logic          eol_q;
    logic          fld_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic          set_close, set_full, clr, wr_here;

    assign set_close = close_now && (wsel_q == 1'(b));
    assign set_full  = fill_done && (tgt_sel == 1'(b));
    assign clr       = rd_fire && rd_last && (rsel_q == 1'(b));
    assign wr_here   = do_write && (tgt_sel == 1'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rdy_q <= 1'b0;
        len_q <= '0;
        eol_q <= 1'b0;
        fld_q <= 1'b0;
      end else begin
        if (set_close) begin
          rdy_q <= 1'b1;
          len_q <= wcnt_q;
          eol_q <= 1'b1;
        end else if (set_full) begin
          rdy_q <= 1'b1;
          len_q <= CW'(DEPTH);
          eol_q <= 1'b0;
        end else if (clr) begin
          rdy_q <= 1'b0;
        end
        if (wr_here) fld_q <= wr_field;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_here) mem_q[tgt_cnt[AW-1:0]] <= wr_data;
    end

    assign bank_ready[b] = rdy_q;
    assign blen[b]       = len_q;
    assign beol[b]       = eol_q;
    assign bfld[b]       = fld_q;
    assign rd_word[b]    = mem_q[rcnt_q[AW-1:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wsel_q <= 1'b0;
      wcnt_q <= '0;
      rsel_q <= 1'b0;
      rcnt_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (fill_done) begin
        wsel_q <= ~tgt_sel;
        wcnt_q <= '0;
      end else if (do_write) begin
        wsel_q <= tgt_sel;
        wcnt_q <= tgt_cnt + CW'(1);
      end else if (close_now) begin
        wsel_q <= ~wsel_q;
        wcnt_q <= '0;
      end
      if (rd_fire) begin
        if (rd_last) begin
          rsel_q <= ~rsel_q;
          rcnt_q <= '0;
        end else begin
          rcnt_q <= rcnt_q + CW'(1);
        end
      end
      if (pix_drop) ovf_q <= 1'b1;
    end
  end

endmodule

// File: rtl/vcap_frontend.sv
module vcap_frontend #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 32,
  parameter int unsigned PW    = 12,
  parameter int unsigned LW    = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    cfg_pol,
  input  logic          cfg_interlace,
  input  logic          vid_valid,
  input  logic          vid_line,
  input  logic          vid_field,
  input  logic          vid_frame,
  input  logic [DW-1:0] vid_data,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_last,
  output logic          out_eol,
  output logic          out_field,
  output logic [PW-1:0] pix_count,
  output logic [LW-1:0] line_count,
  output logic          field_id,
  output logic          line_start,
  output logic          frame_start,
  output logic          overflow
);

  logic          s_valid, s_field, line_edge, frame_edge, field_nxt;
  logic [DW-1:0] s_data;
  logic          pix_drop;
  logic [1:0]    bank_ready;

  vcap_sync #(.DW(DW)) u_sync (
    .clk(clk), .rst_n(rst_n), .cfg_pol(cfg_pol),
    .vid_valid(vid_valid), .vid_line(vid_line), .vid_field(vid_field),
    .vid_frame(vid_frame), .vid_data(vid_data),
    .s_valid(s_valid), .s_field(s_field), .s_data(s_data),
    .line_edge(line_edge), .frame_edge(frame_edge)
  );

  vcap_timing #(.PW(PW), .LW(LW)) u_timing (
    .clk(clk), .rst_n(rst_n), .cfg_interlace(cfg_interlace),
    .s_valid(s_valid), .s_field(s_field),
    .line_edge(line_edge), .frame_edge(frame_edge),
    .pix_count(pix_count), .line_count(line_count),
    .field_id(field_id), .field_nxt(field_nxt),
    .line_start(line_start), .frame_start(frame_start)
  );

  vcap_dbuf #(.DW(DW), .DEPTH(DEPTH)) u_dbuf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(s_valid), .wr_data(s_data), .wr_field(field_nxt),
    .close_req(line_edge | frame_edge), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .out_eol(out_eol), .out_field(out_field), .overflow(overflow),
    .pix_drop(pix_drop), .bank_ready(bank_ready)
  );

endmodule

// File: rtl/vcap_checker.sv
module vcap_checker #(
  parameter int unsigned DW = 16,
  parameter int unsigned PW = 12,
  parameter int unsigned LW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_interlace,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          out_last,
  input logic          out_eol,
  input logic          out_field,
  input logic [PW-1:0] pix_count,
  input logic [LW-1:0] line_count,
  input logic          field_id,
  input logic          line_start,
  input logic          frame_start,
  input logic          overflow,
  input logic          pix_drop,
  input logic [1:0]    bank_ready
);

  p_overflow_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  p_drop_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pix_drop |=> overflow);

  p_drop_only_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pix_drop |-> (bank_ready == 2'b11) || $rose(bank_ready[0]) || $rose(bank_ready[1])
               || (bank_ready != 2'b00));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data) &&
      $stable(out_last) && $stable(out_eol) && $stable(out_field));

  p_pix_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |-> pix_count <= PW'(1));

  p_line_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> line_count == '0);

  p_field_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(field_id) |-> frame_start);

  p_prog_field_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !$past(cfg_interlace)) |-> !field_id);

  p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> !line_start);

  p_eol_on_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_eol |-> out_last && out_valid);

endmodule

bind vcap_frontend vcap_checker #(.DW(DW), .PW(PW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_interlace(cfg_interlace),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_last(out_last), .out_eol(out_eol), .out_field(out_field),
  .pix_count(pix_count), .line_count(line_count), .field_id(field_id),
  .line_start(line_start), .frame_start(frame_start), .overflow(overflow),
  .pix_drop(pix_drop), .bank_ready(bank_ready)
);

// File: tb/sim_vcap_frontend.sv
`timescale 1ns/100ps
module sim_vcap_frontend;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_pol = 4'h0;
  logic        cfg_interlace = 1'b0;
  logic        l_valid = 1'b0, l_line = 1'b0, l_field = 1'b0, l_frame = 1'b0;
  logic [15:0] l_data = '0;
  logic        out_ready = 1'b0;
  logic        out_valid, out_last, out_eol, out_field;
  logic [15:0] out_data;
  logic [11:0] pix_count;
  logic [10:0] line_count;
  logic        field_id, line_start, frame_start, overflow;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vcap_frontend u0 (
    .clk(clk), .rst_n(rst_n), .cfg_pol(cfg_pol), .cfg_interlace(cfg_interlace),
    .vid_valid(l_valid ^ cfg_pol[0]), .vid_line(l_line ^ cfg_pol[1]),
    .vid_field(l_field ^ cfg_pol[2]), .vid_frame(l_frame ^ cfg_pol[3]),
    .vid_data(l_data), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .out_eol(out_eol), .out_field(out_field), .pix_count(pix_count),
    .line_count(line_count), .field_id(field_id), .line_start(line_start),
    .frame_start(frame_start), .overflow(overflow)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [3:0] pol, input logic ilace);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_pol = pol;
    cfg_interlace = ilace;
    l_valid = 0; l_line = 0; l_field = 0; l_frame = 0; out_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_line(input string req);
    @(negedge clk); l_line = 1'b1;
    @(negedge clk); l_line = 1'b0;
    @(posedge clk); #1;
    chk(req, line_start, 1);
    @(posedge clk); #1;
    chk(req, line_start, 0);
    @(negedge clk);
  endtask

  task automatic pulse_frame(input string req);
    @(negedge clk); l_frame = 1'b1;
    @(negedge clk); l_frame = 1'b0;
    @(posedge clk); #1;
    chk(req, frame_start, 1);
    chk(req, line_count, 0);
    @(posedge clk); #1;
    chk(req, frame_start, 0);
    @(negedge clk);
  endtask

  task automatic send_pixels(input int n, input logic [15:0] first);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      l_valid = 1'b1;
      l_data  = first + 16'(i);
    end
    @(negedge clk);
    l_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic drain(input int n, input logic [15:0] first,
                       input bit eol_end, input bit fld, input string req);
    for (int i = 0; i < n; i++) begin
      int waited;
      waited = 0;
      @(negedge clk);
      out_ready = 1'b1;
      while (!out_valid && waited < 50) begin
        @(negedge clk);
        waited++;
      end
      chk(req, out_valid, 1);
      chk(req, out_data, int'(first + 16'(i)));
      chk(req, out_last, int'(((i % 32) == 31) || (i == n - 1)));
      chk(req, out_eol, int'(eol_end && (i == n - 1)));
      chk(req, out_field, int'(fld));
    end
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  // R12: reset values
  task automatic t_reset;
    do_reset(4'h0, 1'b0);
    chk("R12 out_valid", out_valid, 0);
    chk("R12 overflow", overflow, 0);
    chk("R12 field_id", field_id, 0);
    chk("R12 line_start", line_start, 0);
    chk("R12 frame_start", frame_start, 0);
    chk("R12 pix_count", pix_count, 0);
    chk("R12 line_count", line_count, 0);
  endtask

  // R5 R6 R7 R8 progressive burst plus partial line
  task automatic t_progressive;
    do_reset(4'h0, 1'b0);
    pulse_frame("R5 frame strobe");
    pulse_line("R5 line strobe");
    chk("R3 one line", line_count, 1);
    send_pixels(40, 16'h0100);
    chk("R2 forty pixels", pix_count, 40);
    chk("R6 first bank ready", out_valid, 1);
    pulse_line("R7 closing edge");
    chk("R2 restart", pix_count, 0);
    drain(40, 16'h0100, 1'b1, 1'b0, "R6 R7 R11 drain");
    repeat (2) @(negedge clk);
    chk("R7 empty after drain", out_valid, 0);
    pulse_line("R7 empty close");
    repeat (2) @(negedge clk);
    chk("R7 empty close no bank", out_valid, 0);
  endtask

  // R1 R4 R11 inverted polarity, interlaced fields
  task automatic t_interlaced;
    do_reset(4'hF, 1'b1);
    repeat (4) @(negedge clk);
    chk("R1 idle inverted pixel count", pix_count, 0);
    chk("R1 idle inverted no data", out_valid, 0);
    l_field = 1'b1;
    pulse_frame("R1 R5 inverted frame");
    chk("R4 field one", field_id, 1);
    pulse_line("R1 inverted line");
    send_pixels(5, 16'h2000);
    chk("R1 inverted qualifier", pix_count, 5);
    repeat (4) @(negedge clk);
    chk("R1 inactive qualifier ignored", pix_count, 5);
    pulse_line("R7 close");
    drain(5, 16'h2000, 1'b1, 1'b1, "R11 field tag");
    l_field = 1'b0;
    pulse_frame("R4 next field");
    chk("R4 field zero", field_id, 0);
    @(negedge clk);
    cfg_interlace = 1'b0;
    l_field = 1'b1;
    pulse_frame("R4 progressive");
    chk("R4 progressive field", field_id, 0);
    l_field = 1'b0;
  endtask

  // R2 R3 counters
  task automatic t_counters;
    do_reset(4'h0, 1'b0);
    pulse_frame("R3 frame");
    for (int i = 0; i < 3; i++) pulse_line("R3 line");
    chk("R3 three lines", line_count, 3);
    send_pixels(7, 16'h3000);
    chk("R2 seven pixels", pix_count, 7);
    pulse_line("R2 line");
    chk("R2 reset by line", pix_count, 0);
    chk("R3 four lines", line_count, 4);
    pulse_frame("R3 new frame");
    chk("R3 cleared", line_count, 0);
    drain(7, 16'h3000, 1'b1, 1'b0, "R7 counter drain");
  endtask

  // R8 R9 R10 both banks full then overflow
  task automatic t_overflow;
    logic [15:0] held;
    do_reset(4'h0, 1'b0);
    send_pixels(64, 16'h1000);
    chk("R8 data pending", out_valid, 1);
    chk("R9 no overflow yet", overflow, 0);
    @(negedge clk);
    held = out_data;
    repeat (3) @(negedge clk);
    chk("R10 data held", out_data, int'(held));
    chk("R10 first word", out_data, 16'h1000);
    chk("R10 valid held", out_valid, 1);
    send_pixels(1, 16'hBEEF);
    chk("R9 overflow set", overflow, 1);
    drain(64, 16'h1000, 1'b0, 1'b0, "R8 R9 stored words");
    repeat (3) @(negedge clk);
    chk("R9 dropped pixel absent", out_valid, 0);
    chk("R9 sticky", overflow, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_progressive();
    t_interlaced();
    t_counters();
    t_overflow();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule